// File: doc/BRIEF.md
# Page Program Write Buffer

This block holds the data of one page-program command for a serial flash array. While the chip select is low, it counts a fixed 32-bit header off the serial input. The header is an 8-bit command byte that the block skips, then a 24-bit start address, most significant bit first. The data bytes that follow go into a 256-entry page buffer. A separate mode input selects how data arrives: one bit per serial clock edge, or two bits per edge. The buffer's write offset starts at the low address byte and wraps modulo 256, so it never leaves the page. A later byte aimed at an offset replaces the earlier one, which means only the most recent 256 bytes survive.

Each offset has a flag that records whether it received a byte. When the chip select is released, the external admission logic may raise a commit request. If the ending is clean, a walker visits every page offset in ascending order, one per clock. It issues a byte write only for flagged offsets. The array's write port ANDs each byte into the cell, so bits only move from 1 to 0, and offsets that were never sent keep their erased FFh. If the ending is malformed, the block raises an abort pulse instead and writes nothing.

Serial edges reach the block as a one-clock strobe in the system clock domain. The chip select is already synchronous to that clock.

Top module: `pageProgBuf`

## Requirements
- R1: After reset, memWe, commitDone and commitAbort are low.
- R2: A strobe is counted only while csN is low, and only from the second clock after csN falls. The first 32 strobes form the header and carry one bit each on sioIn[0]: 8 command bits that are ignored, then address bits 23 down to 0. In single mode (dualMode=0), each following strobe carries one data bit on sioIn[0], MSB first, and 8 strobes make a byte.
- R3: In dual mode (dualMode=1), each data strobe carries two bits, with the higher-order bit on sioIn[1]. Bits 7 and 6 come first, then 5 and 4, and so on, so 4 strobes make a byte. The header stays one bit per strobe.
- R4: The first byte lands at the offset given by address bits 7..0. Each later byte goes to the next offset modulo 256. Every write of a commit goes to page address bits 23..8.
- R5: When more than 256 bytes are sent, each offset holds the last byte sent to it.
- R6: A commit writes exactly the offsets that received a byte in the current command, with memData equal to the stored byte. Since the array ANDs, untouched bytes stay FFh.
- R7: Offset flags clear when csN falls, so a new command writes none of the previous command's offsets.
- R8: A good commit presents offsets in strictly ascending order over 256 walk slots. commitDone pulses for one clock, 257 clocks after the first clock that samples csN high. No write follows commitDone.
- R9: An abort occurs when csN rises with commitRequest high and the ending is malformed: fewer than 32 header bits, no complete data byte, or a partial byte. In that case commitAbort pulses for one clock, in the cycle after the rise is sampled, and nothing is written.
- R10: With commitReq low at the rise of csN, the block neither commits nor aborts.
- R11: memWe is only high while csN is high, and commitDone and commitAbort are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, synchronous to clk |
| bitStrobe | input | 1 | One-clock pulse per serial rising edge |
| dualMode | input | 1 | 1: two data bits per strobe |
| sioIn | input | 2 | Serial bits; [0] single/low bit, [1] high bit in dual mode |
| commitReq | input | 1 | Command admitted; sampled when csN rises |
| memWe | output | 1 | Array byte write enable |
| memAddr | output | 24 | Array byte address |
| memData | output | 8 | Byte ANDed into the array cell |
| commitDone | output | 1 | One-clock pulse at the end of a commit walk |
| commitAbort | output | 1 | One-clock pulse on a rejected ending |

## Verification
Several kinds of wrong internal state show up at the array port within one commit walk, 257 clocks after the select rises. A stale offset flag produces an extra write or a missing write. A wrong write pointer puts a byte at the wrong offset, and a bad page register puts a write in the wrong page. A bit counter off by one shifts data bits across byte boundaries, so the data is wrong. It also flips the clean-ending decision, which shows as an abort pulse one clock after the select rises, in place of a done pulse.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic startCmd;   // select fell: drop all offset flags
    logic hdrShift;   // header bit on sioIn[0]
    logic hdrLast;    // this header bit completes the address
    logic dataShift;  // data bits present
    logic dualStep;   // two data bits in this strobe
    logic byteDone;   // this strobe completes a data byte
    logic walkStep;   // commit slot for the offset on walkIdx
  } ppbStrb_t;
endpackage

// File: rtl/ppbCtl.sv
module ppbCtl
  import ppb_pkg::*;
#(
  parameter int HDR_BITS   = 32,
  parameter int BYTE_BITS  = 8,
  parameter int PAGE_BYTES = 256,
  localparam int OFFS_W = $clog2(PAGE_BYTES),
  localparam int HCNT_W = $clog2(HDR_BITS + 1),
  localparam int BCNT_W = $clog2(BYTE_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              bitStrobe,
  input  logic              dualMode,
  input  logic              commitReq,
  output ppbStrb_t          strb,
  output logic [OFFS_W-1:0] walkIdx,
  output logic              commitDone,
  output logic              commitAbort
);
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_WALK} ctlState_t;

  ctlState_t         state;
  logic              csPrev;
  logic [HCNT_W-1:0] hdrCnt;
  logic [BCNT_W-1:0] bitCnt;
  logic              gotByte;
  logic              csFall, csRise, cleanEnd;

  assign csFall   = csPrev && !csN;
  assign csRise   = !csPrev && csN;
  assign cleanEnd = (hdrCnt == HCNT_W'(HDR_BITS)) && gotByte && (bitCnt == '0);

  always_comb begin
    strb = '0;
    strb.startCmd = csFall && (state != ST_WALK);
    strb.walkStep = (state == ST_WALK);
    if (state == ST_COLLECT && !csN && bitStrobe) begin
      if (hdrCnt < HCNT_W'(HDR_BITS)) begin
        strb.hdrShift = 1'b1;
        strb.hdrLast  = (hdrCnt == HCNT_W'(HDR_BITS - 1));
      end else begin
        strb.dataShift = 1'b1;
        strb.dualStep  = dualMode;
        strb.byteDone  = dualMode ? (bitCnt == BCNT_W'(BYTE_BITS - 2))
                                  : (bitCnt == BCNT_W'(BYTE_BITS - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      csPrev      <= 1'b1;
      hdrCnt      <= '0;
      bitCnt      <= '0;
      gotByte     <= 1'b0;
      walkIdx     <= '0;
      commitDone  <= 1'b0;
      commitAbort <= 1'b0;
    end else begin
      csPrev      <= csN;
      commitDone  <= 1'b0;
      commitAbort <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (csFall) begin
            state   <= ST_COLLECT;
            hdrCnt  <= '0;
            bitCnt  <= '0;
            gotByte <= 1'b0;
          end
        end
        ST_COLLECT: begin
          if (strb.hdrShift)  hdrCnt  <= hdrCnt + 1'b1;
          if (strb.dataShift) bitCnt  <= bitCnt + (dualMode ? BCNT_W'(2) : BCNT_W'(1));
          if (strb.byteDone)  gotByte <= 1'b1;
          if (csRise) begin
            if (commitReq && cleanEnd) begin
              state   <= ST_WALK;
              walkIdx <= '0;
            end else begin
              state       <= ST_IDLE;
              commitAbort <= commitReq;
            end
          end
        end
        ST_WALK: begin
          walkIdx <= walkIdx + 1'b1;
          if (walkIdx == OFFS_W'(PAGE_BYTES - 1)) begin
            state      <= ST_IDLE;
            commitDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppbData.sv
module ppbData
  import ppb_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BYTE_BITS  = 8,
  parameter int PAGE_BYTES = 256,
  localparam int OFFS_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           sioIn,
  input  ppbStrb_t             strb,
  input  logic [OFFS_W-1:0]    walkIdx,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BYTE_BITS-1:0] memData
);
  logic [ADDR_W-1:0]    addrSh, nextAddr;
  logic [BASE_W-1:0]    pageBase;
  logic [OFFS_W-1:0]    wrPtr;
  logic [BYTE_BITS-1:0] dataSh, nextData;
  logic [BYTE_BITS-1:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMap;

  assign nextAddr = {addrSh[ADDR_W-2:0], sioIn[0]};
  assign nextData = strb.dualStep ? {dataSh[BYTE_BITS-3:0], sioIn}
                                  : {dataSh[BYTE_BITS-2:0], sioIn[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh   <= '0;
      pageBase <= '0;
      wrPtr    <= '0;
      dataSh   <= '0;
    end else begin
      if (strb.hdrShift) addrSh <= nextAddr;
      if (strb.hdrShift && strb.hdrLast) begin
        pageBase <= nextAddr[ADDR_W-1:OFFS_W];
        wrPtr    <= nextAddr[OFFS_W-1:0];
      end
      if (strb.dataShift) dataSh <= nextData;
      if (strb.byteDone)  wrPtr  <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.byteDone) pageBuf[wrPtr] <= nextData;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        validMap[g] <= 1'b0;
      else if (strb.startCmd)                           validMap[g] <= 1'b0;
      else if (strb.byteDone && wrPtr == OFFS_W'(g))    validMap[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe   <= strb.walkStep && validMap[walkIdx];
      memAddr <= {pageBase, walkIdx};
      memData <= pageBuf[walkIdx];
    end
  end
endmodule

// File: rtl/pageProgBuf.sv
module pageProgBuf
  import ppb_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BYTE_BITS  = 8,
  parameter int CMD_BITS   = 8,
  parameter int PAGE_BYTES = 256,
  localparam int OFFS_W   = $clog2(PAGE_BYTES),
  localparam int HDR_BITS = CMD_BITS + ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 bitStrobe,
  input  logic                 dualMode,
  input  logic [1:0]           sioIn,
  input  logic                 commitReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BYTE_BITS-1:0] memData,
  output logic                 commitDone,
  output logic                 commitAbort
);
  ppbStrb_t          strb;
  logic [OFFS_W-1:0] walkIdx;

  ppbCtl #(.HDR_BITS(HDR_BITS), .BYTE_BITS(BYTE_BITS), .PAGE_BYTES(PAGE_BYTES)) i_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .bitStrobe(bitStrobe), .dualMode(dualMode),
    .commitReq(commitReq), .strb(strb), .walkIdx(walkIdx),
    .commitDone(commitDone), .commitAbort(commitAbort)
  );

  ppbData #(.ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .PAGE_BYTES(PAGE_BYTES)) i_data (
    .clk(clk), .rstN(rstN), .sioIn(sioIn), .strb(strb), .walkIdx(walkIdx),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );
endmodule

module pageProgBufChk #(
  parameter int ADDR_W = 24,
  parameter int OFFS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              commitDone,
  input logic              commitAbort
);
  // R11
  we_desel_chk: assert property (@(posedge clk) disable iff (!rstN) memWe |-> csN);
  // R11
  done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(commitDone && commitAbort));
  // R9
  abort_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitAbort |-> ($past(csN) && !$past(csN, 2)));
  // R9
  abort_no_we_chk: assert property (@(posedge clk) disable iff (!rstN) commitAbort |-> !memWe);
  // R8
  done_then_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) commitDone |=> !memWe);
  // R8
  we_ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |->
      ((memAddr[ADDR_W-1:OFFS_W] == $past(memAddr[ADDR_W-1:OFFS_W])) &&
       (memAddr[OFFS_W-1:0] > $past(memAddr[OFFS_W-1:0]))));
endmodule

bind pageProgBuf pageProgBufChk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .memWe(memWe), .memAddr(memAddr),
  .commitDone(commitDone), .commitAbort(commitAbort)
);

// File: tb/test_pageProgBuf.sv
module test_pageProgBuf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, bitStrobe = 1'b0, dualMode = 1'b0, commitReq = 1'b0;
  logic [1:0] sioIn = 2'b00;
  logic memWe, commitDone, commitAbort;
  logic [23:0] memAddr;
  logic [7:0] memData;

  int checks = 0, errors = 0;
  int cyc = 0, riseCyc = 0, doneAt = 0;
  int weCnt = 0, doneCnt = 0, abortCnt = 0, orderErr = 0, lastOff = -1;
  logic [7:0] mem [int];
  logic [7:0] gold [int];
  logic [7:0] payload [0:399];

  always #5 clk = ~clk;

  pageProgBuf i_pageProgBuf (
    .clk(clk), .rstN(rstN), .csN(csN), .bitStrobe(bitStrobe), .dualMode(dualMode),
    .sioIn(sioIn), .commitReq(commitReq), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .commitDone(commitDone), .commitAbort(commitAbort)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // array model: AND into erased cells, observed away from the clock edge
  always @(negedge clk) begin
    if (memWe) begin
      mem[int'(memAddr)] = (mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'hFF) & memData;
      weCnt++;
      if (int'(memAddr[7:0]) <= lastOff) orderErr++;
      lastOff = int'(memAddr[7:0]);
    end
    if (commitDone) begin doneCnt++; doneAt = cyc; end
    if (commitAbort) abortCnt++;
  end

  function automatic logic [7:0] rdMem(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] rdGold(int a);
    return gold.exists(a) ? gold[a] : 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobe(logic [1:0] v);
    @(negedge clk); sioIn = v; bitStrobe = 1'b1;
    @(negedge clk); bitStrobe = 1'b0;
  endtask

  // hdrBits < 32 truncates the header; tailBits adds a partial single-bit byte
  task automatic sendCmd(int addr, int nBytes, bit dual, int hdrBits, int tailBits, bit req);
    logic [31:0] word;
    word = {8'h5A, addr[23:0]};
    @(negedge clk);
    weCnt = 0; doneCnt = 0; abortCnt = 0; orderErr = 0; lastOff = -1;
    csN = 1'b0; dualMode = dual; commitReq = req;
    repeat (2) @(negedge clk);
    for (int i = 0; i < hdrBits; i++) strobe({1'b0, word[31-i]});
    if (hdrBits == 32) begin
      for (int b = 0; b < nBytes; b++) begin
        if (dual) for (int k = 0; k < 4; k++) strobe(payload[b][7-2*k -: 2]);
        else      for (int k = 0; k < 8; k++) strobe({1'b0, payload[b][7-k]});
      end
      for (int t = 0; t < tailBits; t++) strobe({1'b0, 1'b1});
    end
    @(negedge clk); csN = 1'b1; riseCyc = cyc;
    repeat (265) @(negedge clk);
  endtask

  // expected result of a good commit; returns number of touched offsets
  function automatic int applyGold(int addr, int nBytes);
    logic [7:0] shadow [256];
    bit touched [256];
    int n = 0;
    int base = addr & 32'hFFFF00;
    for (int o = 0; o < 256; o++) touched[o] = 0;
    for (int b = 0; b < nBytes; b++) begin
      shadow[(addr + b) & 255] = payload[b];
      touched[(addr + b) & 255] = 1;
    end
    for (int o = 0; o < 256; o++) if (touched[o]) begin
      gold[base + o] = rdGold(base + o) & shadow[o];
      n++;
    end
    return n;
  endfunction

  task automatic cmpPage(int addr, string req);
    int base = addr & 32'hFFFF00;
    int bad = -1;
    for (int o = 255; o >= 0; o--) if (rdMem(base + o) !== rdGold(base + o)) bad = o;
    if (bad < 0) chk(1'b1, req, "page", 0, 0);
    else chk(1'b0, req, $sformatf("page %0h offset %0h", base, bad),
             int'(rdMem(base + bad)), int'(rdGold(base + bad)));
  endtask

  task automatic goodCmd(int addr, int nBytes, bit dual, string req);
    int expW;
    sendCmd(addr, nBytes, dual, 32, 0, 1'b1);
    expW = applyGold(addr, nBytes);
    chk(weCnt == expW, req, "write count", weCnt, expW);
    chk(doneCnt == 1 && abortCnt == 0, "R8", "done/abort pulses", doneCnt * 16 + abortCnt, 16);
    chk(doneAt - riseCyc == 257, "R8", "done latency", doneAt - riseCyc, 257);
    chk(orderErr == 0, "R8", "offset order errors", orderErr, 0);
    cmpPage(addr, req);
  endtask

  task automatic badCmd(int addr, int nBytes, int hdrBits, int tailBits, string what);
    sendCmd(addr, nBytes, 1'b0, hdrBits, tailBits, 1'b1);
    chk(abortCnt == 1, "R9", {what, " abort pulses"}, abortCnt, 1);
    chk(weCnt == 0 && doneCnt == 0, "R9", {what, " writes/done"}, weCnt + doneCnt, 0);
    cmpPage(addr, "R9");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    chk(memWe == 0 && commitDone == 0 && commitAbort == 0, "R1", "outputs in reset", {memWe, commitDone, commitAbort}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(memWe == 0 && commitDone == 0 && commitAbort == 0, "R1", "outputs after reset", {memWe, commitDone, commitAbort}, 0);

    // R2 R4: wrap from the top of the page
    payload[0] = 8'hA5; payload[1] = 8'h3C; payload[2] = 8'h81;
    goodCmd(24'h0000FE, 3, 1'b0, "R4");
    chk(rdMem(24'h000000) == 8'h81, "R4", "wrapped byte at offset 00", int'(rdMem(0)), 8'h81);
    chk(rdMem(24'h000001) == 8'hFF, "R6", "untouched offset 01", int'(rdMem(1)), 8'hFF);

    // R7: new command writes only its own offset; R6 AND into a programmed cell
    payload[0] = 8'h0F;
    goodCmd(24'h0000FE, 1, 1'b0, "R7");
    chk(rdMem(24'h0000FE) == 8'h05, "R6", "AND into programmed cell", int'(rdMem(24'hFE)), 8'h05);

    // R3: dual-bit data
    payload[0] = 8'hC9; payload[1] = 8'h36; payload[2] = 8'h5A; payload[3] = 8'hE1;
    goodCmd(24'h012310, 4, 1'b1, "R3");
    chk(rdMem(24'h012311) == 8'h36, "R3", "dual byte order", int'(rdMem(24'h012311)), 8'h36);

    // R5: more than a page, last 256 kept
    for (int b = 0; b < 300; b++) payload[b] = 8'(b * 7 + 3);
    goodCmd(24'h0A5580, 300, 1'b0, "R5");
    chk(rdMem(24'h0A5580) == payload[256], "R5", "overwritten start offset", int'(rdMem(24'h0A5580)), int'(payload[256]));

    // R9: malformed endings
    badCmd(24'h033300, 0, 20, 0, "short header");
    badCmd(24'h033300, 0, 32, 0, "no data byte");
    payload[0] = 8'h11; payload[1] = 8'h22;
    badCmd(24'h033300, 2, 32, 3, "partial byte");

    // R10: not admitted
    sendCmd(24'h044400, 2, 1'b0, 32, 0, 1'b0);
    chk(weCnt == 0 && doneCnt == 0 && abortCnt == 0, "R10", "activity without request", weCnt + doneCnt + abortCnt, 0);
    cmpPage(24'h044400, "R10");

    // random commands over a few pages, both modes
    for (int r = 0; r < 12; r++) begin
      int addr = int'({4'h0, 8'($urandom_range(0, 5)), 4'h0, 8'($urandom)});
      int n = $urandom_range(1, 320);
      bit d = 1'($urandom);
      for (int b = 0; b < n; b++) payload[b] = 8'($urandom);
      goodCmd(addr, n, d, d ? "R3" : "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule